// File: doc/BRIEF.md
# Peripheral Bus Adapter Register File

This block is the register file of an adapter that connects a longword-wide system interconnect to a slower peripheral bus. Each request carries a byte address, a size code, a direction and write data. The block takes the longword offset from the address and works out which register the request selects. It either performs the access or answers with a nonexistent-location flag. The registers are:

- configuration, control, status and diagnostic registers;
- four interrupt-service registers and four vector windows;
- sixteen data-path registers;
- an address-map table.

External event inputs set the error flags that software clears by writing ones. A single adapter-level interrupt request output reports those flags.

A small sequencer with three states controls the initialisation and power-fail timing. RUN is the idle state. INIT means an adapter initialisation is in progress. PFAIL means a peripheral-bus power-fail interval is running. The transitions are:

- RUN→INIT, INIT→INIT and PFAIL→INIT on an init command, which reloads the timer with the init duration.
- RUN→PFAIL on a rising power-fail control bit, which loads the init duration plus the peripheral-init duration.
- INIT→RUN and PFAIL→RUN when the timer reaches its last cycle. This also sets the done flag in status.

Responses and the error-confirmation pulse are registered, so each appears one cycle after its request.

Top module: `busadp_regs`

## Requirements
- R1: A request with address bits [1:0] not zero, or with a size code other than 2 (longword), changes no register and gives no response. Instead, one cycle later, `err_cnf` pulses high while `rsp_valid` stays low.
- R2: While init is in progress, writes succeed only to word offsets 0 to 3 (configuration, control, status, diagnostic), and reads succeed only from offsets 0 and 3. Any other access responds with `rsp_nxm` set.
- R3: Word offsets from 512 upward select map entry (offset−512). An entry index of MAP_DEPTH or more responds nonexistent. A map write stores only the bits of 0x801F_FFFF, and a map read returns only the bits of 0x800F_FFFF.
- R4: Configuration bits [31:16] are set by `cnf_err_set` and cleared by writing ones to them. Status bits [4:0] clear the same way. A write to the diagnostic register (offset 3) also clears the configuration bits [31:16] that are set in its data.
- R5: A control write (offset 1) with bit 0 set does three things. It clears configuration, control, status, diagnostic, interrupt-service and data-path state. It enters INIT for INIT_CYC cycles. On leaving INIT it sets status bit 4 (done).
- R6: A control write that raises bit 1 from 0 to 1 starts a PFAIL interval of INIT_CYC+PU_CYC cycles that ends by setting status bit 4. It does so only when the sequencer is in RUN; a rise during a running interval does not restart it.
- R7: The error condition is that configuration bits [31:16] or status bits [3:0] are nonzero. `irq` rises after a control write that raises any of control bits [6:1] while the error condition holds. After any write to configuration, control, status or diagnostic, `irq` drops if the condition is false. At no other time does `irq` rise.
- R8: A configuration read returns bits [31:16] ORed with the type code 0x28. A diagnostic read returns diagnostic bits [13:8], the constant bit 15, configuration bits [31:16] and the code 0x28.
- R9: Data-path register 0 (offset 16) ignores writes and reads as zero. Data-path registers 1 to 15 (offsets 17 to 31) hold bit 31, which is set by `dp_flag_set[i]` and cleared by writing a one to it. Reads return only bit 31.
- R10: Interrupt-service registers (offsets 4 to 7) are plain 32-bit read/write. A read of vector window k (offsets 8 to 11) returns the value present on `vec_in[k*16 +: 16]` in the request cycle, zero-extended.
- R11: After reset every register is zero: configuration reads 0x28, control and status read 0, and `irq` is 0. Offsets 12 to 15 and 32 to 511 respond nonexistent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the adapter window |
| req_size | input | 2 | 0 byte, 1 word, 2 longword |
| req_wdata | input | 32 | Write data |
| vec_in | input | 4*VEC_W | Current vector per request level |
| cnf_err_set | input | 16 | Sets configuration bits [31:16] |
| sts_err_set | input | 4 | Sets status bits [3:0] |
| dp_flag_set | input | 16 | Sets bit 31 of the matching data-path register |
| rsp_valid | output | 1 | Response for an aligned longword request |
| rsp_nxm | output | 1 | Nonexistent-location response |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| err_cnf | output | 1 | Error-confirmation pulse for a bad access shape |
| irq | output | 1 | Adapter interrupt request |

## Verification
The bench targets the asymmetric read and write permission sets during INIT. A design that used a single set would either reject the status write or accept the status read. The power-fail test raises the control bit a second time while an interval is running and then samples status between the original and the restarted expiry times; a design that reloads the timer shows the done bit late. The interrupt tests cover three cases: a rising control bit with no pending error, a repeated control write with no rise, and clearing the errors one register at a time. These catch a request that is tied to the control value instead of to its rising edge, or that is never re-evaluated. The diagnostic write clearing configuration bits and the direct data-path register 0 cover side effects that a plain register model would leave out.

// File: rtl/busadp_pkg.sv
package busadp_pkg;

    typedef enum logic [3:0] {
        RG_CNF,
        RG_CTRL,
        RG_STAT,
        RG_DIAG,
        RG_SVR,
        RG_VEC,
        RG_DP,
        RG_MAP,
        RG_NONE
    } region_e;

    typedef enum logic [1:0] {
        S_RUN,
        S_INIT,
        S_PFAIL
    } seq_e;

    localparam logic [1:0] SZ_LONG = 2'd2;

endpackage

// File: rtl/busadp_decode.sv
module busadp_decode
    import busadp_pkg::*;
#(
    parameter int OFS_W     = 10,
    parameter int MAP_BASE  = 512,
    parameter int MAP_DEPTH = 496,
    localparam int MAP_IDX_W = $clog2(MAP_DEPTH)
) (
    input  logic [OFS_W-1:0]     ofs,
    output region_e              region,
    output logic [3:0]           sub,
    output logic [MAP_IDX_W-1:0] map_idx,
    output logic                 map_ok
);

    logic [OFS_W-1:0] map_diff;

    always_comb begin
        map_diff = ofs - OFS_W'(MAP_BASE);
        map_idx  = map_diff[MAP_IDX_W-1:0];
        map_ok   = (map_diff < OFS_W'(MAP_DEPTH));
        sub      = ofs[3:0];
        region   = RG_NONE;
        if (ofs >= OFS_W'(MAP_BASE)) begin
            region = RG_MAP;
        end else if (ofs == OFS_W'(0)) begin
            region = RG_CNF;
        end else if (ofs == OFS_W'(1)) begin
            region = RG_CTRL;
        end else if (ofs == OFS_W'(2)) begin
            region = RG_STAT;
        end else if (ofs == OFS_W'(3)) begin
            region = RG_DIAG;
        end else if (ofs[OFS_W-1:2] == (OFS_W-2)'(1)) begin
            region = RG_SVR;
        end else if (ofs[OFS_W-1:2] == (OFS_W-2)'(2)) begin
            region = RG_VEC;
        end else if (ofs[OFS_W-1:4] == (OFS_W-4)'(1)) begin
            region = RG_DP;
        end
    end

endmodule

// File: rtl/busadp_seq.sv
module busadp_seq
    import busadp_pkg::*;
#(
    parameter int INIT_CYC = 20,
    parameter int PU_CYC   = 30,
    localparam int CNT_W   = $clog2(INIT_CYC + PU_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_init,
    input  logic start_pf,
    output logic aiip,
    output logic busy,
    output logic expire
);

    seq_e             state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_RUN: begin
                if (start_init) begin
                    state_d = S_INIT;
                    cnt_d   = CNT_W'(INIT_CYC);
                end else if (start_pf) begin
                    state_d = S_PFAIL;
                    cnt_d   = CNT_W'(INIT_CYC + PU_CYC);
                end
            end
            S_INIT, S_PFAIL: begin
                if (start_init) begin
                    state_d = S_INIT;
                    cnt_d   = CNT_W'(INIT_CYC);
                end else if (cnt_q == CNT_W'(1)) begin
                    state_d = S_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: begin
                state_d = S_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        aiip   = (state_q == S_INIT);
        busy   = (state_q != S_RUN);
        expire = busy && !start_init && (cnt_q == CNT_W'(1));
    end

    // R5: an init command always loads the init duration
    p_init_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_init |=> (state_q == S_INIT) && (cnt_q == CNT_W'(INIT_CYC)));

    // R5: a running interval counts down by one per cycle
    p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start_init && cnt_q != CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R6: a power-fail start from idle loads the long duration
    p_pf_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_pf && !start_init) |=> (state_q == S_PFAIL) && (cnt_q == CNT_W'(INIT_CYC + PU_CYC)));

    // R6: a running power-fail interval is never reloaded by another start
    p_pf_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PFAIL && !start_init && cnt_q != CNT_W'(1)) |=> (cnt_q != CNT_W'(INIT_CYC + PU_CYC)));

endmodule

// File: rtl/busadp_regs.sv
module busadp_regs
    import busadp_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          VEC_W     = 16,
    parameter int          MAP_BASE  = 512,
    parameter int          MAP_DEPTH = 496,
    parameter int          INIT_CYC  = 20,
    parameter int          PU_CYC    = 30,
    parameter logic [31:0] CNF_W1C   = 32'hFFFF_0000,
    parameter logic [31:0] CNF_CODE  = 32'h0000_0028,
    parameter logic [31:0] CR_WR     = 32'h0000_007E,
    parameter logic [31:0] CR_INIT   = 32'h0000_0001,
    parameter logic [31:0] CR_PF     = 32'h0000_0002,
    parameter logic [31:0] STS_W1C   = 32'h0000_001F,
    parameter logic [31:0] STS_ERR   = 32'h0000_000F,
    parameter logic [31:0] STS_DONE  = 32'h0000_0010,
    parameter logic [31:0] DR_WR     = 32'h0000_3F00,
    parameter logic [31:0] DR_MICOK  = 32'h0000_8000,
    parameter logic [31:0] DP_W1C    = 32'h8000_0000,
    parameter logic [31:0] MAP_WR    = 32'h801F_FFFF,
    parameter logic [31:0] MAP_RD    = 32'h800F_FFFF,
    localparam int         OFS_W     = ADDR_W - 2,
    localparam int         MAP_IDX_W = $clog2(MAP_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    input  logic [4*VEC_W-1:0] vec_in,
    input  logic [15:0]       cnf_err_set,
    input  logic [3:0]        sts_err_set,
    input  logic [15:0]       dp_flag_set,
    output logic              rsp_valid,
    output logic              rsp_nxm,
    output logic [31:0]       rsp_rdata,
    output logic              err_cnf,
    output logic              irq
);

    region_e              region;
    logic [3:0]           sub;
    logic [MAP_IDX_W-1:0] map_idx;
    logic                 map_ok;
    logic                 aiip, busy, expire;
    logic                 start_init, start_pf;
    logic                 aligned, allowed, nxm, act;

    logic [31:0] cnf_q, cnf_d, cr_q, cr_d, sts_q, sts_d, dr_q, dr_d, rise;
    logic [31:0] svr_q [4];
    logic [31:0] svr_d [4];
    logic [31:0] dp_q  [16];
    logic [31:0] dp_d  [16];
    logic [31:0] map_mem [MAP_DEPTH];
    logic [31:0] rdata, vec_sel;
    logic        pend, irq_d;

    busadp_decode #(
        .OFS_W     (OFS_W),
        .MAP_BASE  (MAP_BASE),
        .MAP_DEPTH (MAP_DEPTH)
    ) u_decode (
        .ofs     (req_addr[ADDR_W-1:2]),
        .region  (region),
        .sub     (sub),
        .map_idx (map_idx),
        .map_ok  (map_ok)
    );

    busadp_seq #(
        .INIT_CYC (INIT_CYC),
        .PU_CYC   (PU_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_init (start_init),
        .start_pf   (start_pf),
        .aiip       (aiip),
        .busy       (busy),
        .expire     (expire)
    );

    // access shape and permission
    always_comb begin
        aligned = (req_addr[1:0] == 2'b00) && (req_size == SZ_LONG);
        if (!aiip)
            allowed = 1'b1;
        else if (req_write)
            allowed = (region == RG_CNF) || (region == RG_CTRL) ||
                      (region == RG_STAT) || (region == RG_DIAG);
        else
            allowed = (region == RG_CNF) || (region == RG_DIAG);
        nxm = (region == RG_NONE) || ((region == RG_MAP) && !map_ok) || !allowed;
        act = req_valid && aligned && !nxm;
    end

    // next register state
    always_comb begin
        cnf_d      = cnf_q | {cnf_err_set, 16'h0000};
        sts_d      = sts_q | {28'h0, sts_err_set} | (expire ? STS_DONE : 32'h0);
        cr_d       = cr_q;
        dr_d       = dr_q;
        rise       = '0;
        start_init = 1'b0;
        start_pf   = 1'b0;
        for (int i = 0; i < 4; i++) svr_d[i] = svr_q[i];
        for (int i = 0; i < 16; i++) dp_d[i] = dp_q[i] | (dp_flag_set[i] ? DP_W1C : 32'h0);
        if (act && req_write) begin
            unique case (region)
                RG_CNF:  cnf_d = cnf_d & ~(req_wdata & CNF_W1C);
                RG_CTRL: begin
                    if ((req_wdata & CR_INIT) != 32'h0) begin
                        start_init = 1'b1;
                        cnf_d = '0;
                        sts_d = '0;
                        dr_d  = '0;
                        for (int i = 0; i < 4; i++) svr_d[i] = '0;
                        for (int i = 0; i < 16; i++) dp_d[i] = '0;
                    end
                    start_pf = ((req_wdata & CR_PF) != 32'h0) && ((cr_q & CR_PF) == 32'h0);
                    cr_d     = req_wdata & CR_WR;
                    rise     = cr_d & ~cr_q;
                end
                RG_STAT: sts_d = sts_d & ~(req_wdata & STS_W1C);
                RG_DIAG: begin
                    dr_d  = req_wdata & DR_WR;
                    cnf_d = cnf_d & ~(req_wdata & CNF_W1C);
                end
                RG_SVR:  svr_d[sub[1:0]] = req_wdata;
                RG_DP:   if (sub != 4'd0) dp_d[sub] = dp_d[sub] & ~(req_wdata & DP_W1C);
                default: ;
            endcase
        end
        pend  = ((cnf_d & CNF_W1C) != 32'h0) || ((sts_d & STS_ERR) != 32'h0);
        irq_d = irq;
        if (act && req_write) begin
            if (region == RG_CTRL)
                irq_d = (irq || (rise != 32'h0)) && pend;
            else if ((region == RG_CNF) || (region == RG_STAT) || (region == RG_DIAG))
                irq_d = irq && pend;
        end
    end

    // read data
    always_comb begin
        vec_sel = {{(32-VEC_W){1'b0}}, vec_in[sub[1:0]*VEC_W +: VEC_W]};
        unique case (region)
            RG_CNF:  rdata = (cnf_q & CNF_W1C) | CNF_CODE;
            RG_CTRL: rdata = cr_q & CR_WR;
            RG_STAT: rdata = sts_q & STS_W1C;
            RG_DIAG: rdata = (dr_q & DR_WR) | DR_MICOK | (cnf_q & CNF_W1C) | CNF_CODE;
            RG_SVR:  rdata = svr_q[sub[1:0]];
            RG_VEC:  rdata = vec_sel;
            RG_DP:   rdata = (sub == 4'd0) ? 32'h0 : (dp_q[sub] & DP_W1C);
            RG_MAP:  rdata = map_mem[map_idx] & MAP_RD;
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnf_q     <= '0;
            cr_q      <= '0;
            sts_q     <= '0;
            dr_q      <= '0;
            irq       <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_nxm   <= 1'b0;
            rsp_rdata <= '0;
            err_cnf   <= 1'b0;
            for (int i = 0; i < 4; i++) svr_q[i] <= '0;
            for (int i = 0; i < 16; i++) dp_q[i] <= '0;
        end else begin
            cnf_q     <= cnf_d;
            cr_q      <= cr_d;
            sts_q     <= sts_d;
            dr_q      <= dr_d;
            irq       <= irq_d;
            rsp_valid <= req_valid && aligned;
            rsp_nxm   <= req_valid && aligned && nxm;
            rsp_rdata <= (act && !req_write) ? rdata : 32'h0;
            err_cnf   <= req_valid && !aligned;
            for (int i = 0; i < 4; i++) svr_q[i] <= svr_d[i];
            for (int i = 0; i < 16; i++) dp_q[i] <= dp_d[i];
        end
    end

    // map table keeps its contents across reset
    always_ff @(posedge clk) begin
        if (act && req_write && (region == RG_MAP))
            map_mem[map_idx] <= req_wdata & MAP_WR;
    end

    p_bad_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !aligned) |=> (err_cnf && !rsp_valid));

    p_init_read_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && aligned && !req_write && aiip &&
         region != RG_CNF && region != RG_DIAG) |=> (rsp_valid && rsp_nxm));

    p_map_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && aligned && region == RG_MAP && !map_ok) |=> (rsp_valid && rsp_nxm));

    p_irq_only_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !(act && req_write && region == RG_CTRL)) |=> !irq);

    p_dp0_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && aligned && !req_write && !aiip && region == RG_DP && sub == 4'd0)
        |=> (rsp_rdata == 32'h0));

endmodule

// File: tb/busadp_regs_bench.sv
`timescale 1ns/1ps
module busadp_regs_bench;

    localparam int INIT_CYC = 20;
    localparam int PU_CYC   = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_wdata = '0;
    logic [63:0] vec_in = '0;
    logic [15:0] cnf_err_set = '0;
    logic [3:0]  sts_err_set = '0;
    logic [15:0] dp_flag_set = '0;
    logic        rsp_valid, rsp_nxm, err_cnf, irq;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;

    logic        s_valid, s_nxm, s_err;
    logic [31:0] s_data;

    always #4 clk = ~clk;

    busadp_regs #(.INIT_CYC(INIT_CYC), .PU_CYC(PU_CYC)) u_busadp_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .vec_in(vec_in), .cnf_err_set(cnf_err_set), .sts_err_set(sts_err_set),
        .dp_flag_set(dp_flag_set), .rsp_valid(rsp_valid), .rsp_nxm(rsp_nxm),
        .rsp_rdata(rsp_rdata), .err_cnf(err_cnf), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [11:0] addr, input logic [1:0] sz,
                          input logic [31:0] wd);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        s_valid = rsp_valid; s_nxm = rsp_nxm; s_err = err_cnf; s_data = rsp_rdata;
    endtask

    task automatic rd(input logic [11:0] addr);
        access(1'b0, addr, 2'd2, 32'h0);
    endtask

    task automatic wr(input logic [11:0] addr, input logic [31:0] wd);
        access(1'b1, addr, 2'd2, wd);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rd(12'h000); check("R11 cnf reset", s_data, 32'h28); check("R8 cnf code", {31'b0, s_nxm}, 0);
        rd(12'h004); check("R11 ctrl reset", s_data, 0);
        rd(12'h008); check("R11 stat reset", s_data, 0);
        check("R11 irq reset", {31'b0, irq}, 0);
    endtask

    task automatic t_shape;
        access(1'b0, 12'h001, 2'd2, 0);
        check("R1 misaligned err", {30'b0, s_err, s_valid}, 32'h2);
        access(1'b1, 12'h004, 2'd1, 32'h7E);
        check("R1 short size err", {30'b0, s_err, s_valid}, 32'h2);
        rd(12'h004); check("R1 no write done", s_data, 0);
    endtask

    task automatic t_map;
        wr(12'h814, 32'hFFFF_FFFF); check("R3 map write ok", {31'b0, s_nxm}, 0);
        rd(12'h814); check("R3 map masks", s_data, 32'h800F_FFFF);
        wr(12'hFBC, 32'h0012_3456); rd(12'hFBC); check("R3 last entry", s_data, 32'h0002_3456);
        rd(12'hFC0); check("R3 beyond depth", {30'b0, s_valid, s_nxm}, 32'h3);
    endtask

    task automatic t_w1c;
        cnf_err_set = 16'h00F0; @(negedge clk); cnf_err_set = '0;
        rd(12'h000); check("R4 cnf set", s_data, 32'h00F0_0028);
        wr(12'h000, 32'h0030_0000); rd(12'h000); check("R4 cnf w1c", s_data, 32'h00C0_0028);
        wr(12'h00C, 32'h0040_FFFF); rd(12'h000); check("R4 diag clears cnf", s_data, 32'h0080_0028);
        rd(12'h00C); check("R8 diag read", s_data, 32'h0080_BF28);
        sts_err_set = 4'hF; @(negedge clk); sts_err_set = '0;
        wr(12'h008, 32'h3); rd(12'h008); check("R4 stat w1c", s_data, 32'hC);
    endtask

    task automatic t_irq;
        wr(12'h004, 32'h40); check("R7 irq on rise", {31'b0, irq}, 1);
        wr(12'h004, 32'h40); check("R7 irq held", {31'b0, irq}, 1);
        wr(12'h000, 32'h0080_0000); check("R7 irq cnf clear pend", {31'b0, irq}, 1);
        wr(12'h008, 32'hC); check("R7 irq drops", {31'b0, irq}, 0);
        wr(12'h004, 32'h0); wr(12'h004, 32'h20); check("R7 no irq without error", {31'b0, irq}, 0);
        sts_err_set = 4'h1; @(negedge clk); sts_err_set = '0; idle(2);
        check("R7 no irq from event", {31'b0, irq}, 0);
        wr(12'h008, 32'h1);
    endtask

    task automatic t_dp;
        dp_flag_set = 16'h0009; @(negedge clk); dp_flag_set = '0;
        wr(12'h040, 32'hFFFF_FFFF); rd(12'h040); check("R9 dp0 reads zero", s_data, 0);
        rd(12'h04C); check("R9 dp3 flag", s_data, 32'h8000_0000);
        wr(12'h04C, 32'h7FFF_FFFF); rd(12'h04C); check("R9 dp3 zero write", s_data, 32'h8000_0000);
        wr(12'h04C, 32'h8000_0000); rd(12'h04C); check("R9 dp3 cleared", s_data, 0);
    endtask

    task automatic t_vec;
        wr(12'h018, 32'hDEAD_BEEF); rd(12'h018); check("R10 svr rw", s_data, 32'hDEAD_BEEF);
        rd(12'h010); check("R10 svr other", s_data, 0);
        vec_in = 64'h0000_1234_0000_0000; rd(12'h028); check("R10 vector", s_data, 32'h1234);
        vec_in = 64'h0000_0ABC_0000_0000; rd(12'h028); check("R10 vector fresh", s_data, 32'h0ABC);
    endtask

    task automatic t_unmapped;
        rd(12'h030); check("R11 hole 12", {31'b0, s_nxm}, 1);
        wr(12'h0A0, 32'h1); check("R11 hole 40", {31'b0, s_nxm}, 1);
    endtask

    task automatic t_init;
        wr(12'h004, 32'h04);
        sts_err_set = 4'h2; @(negedge clk); sts_err_set = '0;
        wr(12'h004, 32'h1);
        rd(12'h004); check("R2 ctrl read blocked", {31'b0, s_nxm}, 1);
        rd(12'h000); check("R2 cnf read ok", {s_nxm, s_data[30:0]}, 32'h28);
        wr(12'h010, 32'h5); check("R2 svr write blocked", {31'b0, s_nxm}, 1);
        wr(12'h008, 32'h0); check("R2 stat write ok", {31'b0, s_nxm}, 0);
        rd(12'h008); check("R2 stat read blocked", {31'b0, s_nxm}, 1);
        idle(INIT_CYC);
        rd(12'h004); check("R5 ctrl cleared", {s_nxm, s_data[30:0]}, 0);
        rd(12'h008); check("R5 done only", s_data, 32'h10);
        rd(12'h018); check("R5 svr cleared", s_data, 0);
    endtask

    task automatic t_upf;
        wr(12'h008, 32'h10);
        wr(12'h004, 32'h2);
        wr(12'h004, 32'h0);
        idle(28);
        wr(12'h004, 32'h2);
        idle(9);
        rd(12'h008); check("R6 still running", s_data, 0);
        idle(14);
        rd(12'h008); check("R6 done without restart", s_data, 32'h10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_shape;
        t_map;
        t_w1c;
        t_irq;
        t_dp;
        t_vec;
        t_unmapped;
        t_init;
        t_upf;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule